// File: doc/BRIEF.md
# CPU Clock Source and Ratio Control Registers

This block is the register front end for the clocks of a CPU domain. Software selects the parent of the core clock and the source of the performance-monitor clock through one select register. It also programs four 3-bit ratio fields spread over two divider registers. The block does not generate clocks. It models the time real hardware takes to complete each change, so that software can poll for completion.

Every writable control has a status register beside it. When a select bit changes, its status field shows a transition code for a fixed number of cycles. After that it shows which parent is active. A second change that arrives during a switch is held and applied when the current switch ends. When a ratio field changes value, a busy bit for that field reads one for a fixed number of cycles.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset every readable register returns zero, except mux status (0x200), which returns 0x00110000: main parent active on both mux fields, no transition.
- R2: The select register (0x000) stores bit 16 (core parent: 0 main, 1 alternate) and bit 20 (performance-monitor source). A write takes effect on readback in the next cycle. All other bits read zero.
- R3: After a write changes bit 16, mux status bits [18:16] read 4 for MUX_SETTLE cycles. They then read 2 if the alternate parent is selected or 1 if the main parent is selected.
- R4: Mux status bits [22:20] follow bit 20 of the select register with the same encoding and the same timing as R3.
- R5: A select write that leaves a bit at its active value, with no switch in progress, starts no transition. That status field keeps its value.
- R6: A select write made during a switch is held. When the current switch finishes, a new switch toward the newest value starts at once, and the status keeps reading 4 until that switch ends.
- R7: Divider 0 (0x300) stores the core ratio in bits [2:0] and the trace-bus ratio in bits [18:16]. Divider 1 (0x304) stores the copy ratio in bits [2:0] and the performance-monitor ratio in bits [6:4]. Other bits read zero.
- R8: A write that changes a ratio field sets that field's busy bit for DIV_SETTLE cycles, then clears it. The busy bit sits at the field's lowest bit position in the matching status register: 0x400 bits 0 and 16, 0x404 bits 0 and 4.
- R9: A write that leaves a ratio field unchanged does not set its busy bit. A changing write while the field is busy restarts that field's full delay.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets and to the three status registers change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A wrong internal counter or held target appears at the ports as a transition code or busy bit whose length is off. The error shows up in the first cycle the status should have changed, which is MUX_SETTLE or DIV_SETTLE cycles after the write. A held select value that is lost shows at the end of the first switch: the status falls back to a parent code one switch too early. A decode fault shows as a register that reads back the wrong value on the cycle right after a write.

// File: rtl/cpu_clk_ctrl_pkg.sv
package cpu_clk_ctrl_pkg;

  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int RATIO_W = 3;
  localparam int MSTAT_W = 3;

  localparam logic [ADDR_W-1:0] OFS_SEL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SELST  = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_RAT0   = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_RAT1   = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_RAT0ST = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_RAT1ST = 12'h404;

  // select fields: core parent, perf-monitor source
  localparam int NUM_MUX = 2;
  localparam int MUX_POS [NUM_MUX] = '{16, 20};

  // ratio fields: which divider register and which bit position
  localparam int NUM_DIV = 4;
  localparam int DIV_REG [NUM_DIV] = '{0, 0, 1, 1};
  localparam int DIV_POS [NUM_DIV] = '{0, 16, 0, 4};

  typedef enum logic [MSTAT_W-1:0] {
    MST_MAIN   = 3'd1,
    MST_ALT    = 3'd2,
    MST_MOVING = 3'd4
  } mux_stat_e;

endpackage

// File: rtl/mux_switch_track.sv
module mux_switch_track
  import cpu_clk_ctrl_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic               wr_bit,
  output logic               sel_o,
  output logic [MSTAT_W-1:0] status_o
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          sel_q, sel_n;
  logic          act_q, act_n;
  logic          tgt_q, tgt_n;
  logic          mov_q, mov_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          step_en;

  always_comb begin
    sel_n = wr_hit ? wr_bit : sel_q;
    act_n = act_q;
    tgt_n = tgt_q;
    mov_n = mov_q;
    cnt_n = cnt_q;
    if (mov_q) begin
      if (cnt_q == CNT_ONE) begin
        act_n = tgt_q;
        if (sel_n != tgt_q) begin
          tgt_n = sel_n;
          cnt_n = CNT_LOAD;
        end else begin
          mov_n = 1'b0;
          cnt_n = '0;
        end
      end else begin
        cnt_n = cnt_q - CNT_ONE;
      end
    end else if (sel_n != act_q) begin
      mov_n = 1'b1;
      tgt_n = sel_n;
      cnt_n = CNT_LOAD;
    end
  end

  assign step_en = wr_hit | mov_q | (sel_q != act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      act_q <= 1'b0;
      tgt_q <= 1'b0;
      mov_q <= 1'b0;
      cnt_q <= '0;
    end else if (step_en) begin
      sel_q <= sel_n;
      act_q <= act_n;
      tgt_q <= tgt_n;
      mov_q <= mov_n;
      cnt_q <= cnt_n;
    end
  end

  assign sel_o    = sel_q;
  assign status_o = mov_q ? MST_MOVING : (act_q ? MST_ALT : MST_MAIN);

  // R3
  moving_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mov_q |-> (cnt_q != '0));

  // R3
  switch_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_q && cnt_q == CNT_ONE) |=> (act_q == $past(tgt_q)));

  // R5
  parent_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(mov_q));

  // R6
  switch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_q && cnt_q != CNT_ONE) |=> mov_q);

endmodule

// File: rtl/div_ratio_track.sv
module div_ratio_track #(
  parameter int W      = 3,
  parameter int SETTLE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val_o,
  output logic         busy_o
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [W-1:0]  val_q, val_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          chg;
  logic          upd_en;

  assign chg    = wr_hit && (wr_val != val_q);
  assign upd_en = chg || (cnt_q != '0);

  always_comb begin
    val_n = val_q;
    cnt_n = cnt_q;
    if (chg) begin
      val_n = wr_val;
      cnt_n = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      val_q <= val_n;
      cnt_q <= cnt_n;
    end
  end

  assign val_o  = val_q;
  assign busy_o = (cnt_q != '0);

  // R8
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_hit));

  // R9
  same_value_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_val == val_q && !busy_o) |=> !busy_o);

  // R8
  ratio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(val_o));

endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
  import cpu_clk_ctrl_pkg::*;
#(
  parameter int MUX_SETTLE = 16,
  parameter int DIV_SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic hit_sel, hit_rat0, hit_rat1;
  logic [2:0] hit_vec;

  assign hit_sel  = bus_we && (bus_addr == OFS_SEL);
  assign hit_rat0 = bus_we && (bus_addr == OFS_RAT0);
  assign hit_rat1 = bus_we && (bus_addr == OFS_RAT1);
  assign hit_vec  = {hit_rat1, hit_rat0, hit_sel};

  logic [NUM_MUX-1:0]              msel;
  logic [NUM_MUX-1:0][MSTAT_W-1:0] mstat;
  logic [NUM_DIV-1:0][RATIO_W-1:0] dval;
  logic [NUM_DIV-1:0]              dbusy;

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    mux_switch_track #(.SETTLE(MUX_SETTLE)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_hit   (hit_sel),
      .wr_bit   (bus_wdata[MUX_POS[m]]),
      .sel_o    (msel[m]),
      .status_o (mstat[m])
    );
  end

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    logic d_hit;
    assign d_hit = (DIV_REG[d] == 0) ? hit_rat0 : hit_rat1;
    div_ratio_track #(.W(RATIO_W), .SETTLE(DIV_SETTLE)) u_div (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .wr_hit (d_hit),
      .wr_val (bus_wdata[DIV_POS[d] +: RATIO_W]),
      .val_o  (dval[d]),
      .busy_o (dbusy[d])
    );
  end

  logic [DATA_W-1:0]      sel_word, selst_word;
  logic [1:0][DATA_W-1:0] rat_word, ratst_word;

  always_comb begin
    sel_word   = '0;
    selst_word = '0;
    rat_word   = '0;
    ratst_word = '0;
    for (int m = 0; m < NUM_MUX; m++) begin
      sel_word[MUX_POS[m]]             = msel[m];
      selst_word[MUX_POS[m] +: MSTAT_W] = mstat[m];
    end
    for (int d = 0; d < NUM_DIV; d++) begin
      rat_word[DIV_REG[d]][DIV_POS[d] +: RATIO_W] = dval[d];
      ratst_word[DIV_REG[d]][DIV_POS[d]]          = dbusy[d];
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_SEL:    bus_rdata = sel_word;
      OFS_SELST:  bus_rdata = selst_word;
      OFS_RAT0:   bus_rdata = rat_word[0];
      OFS_RAT1:   bus_rdata = rat_word[1];
      OFS_RAT0ST: bus_rdata = ratst_word[0];
      OFS_RAT1ST: bus_rdata = ratst_word[1];
      default:    bus_rdata = '0;
    endcase
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit_vec));

  // R10
  sel_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hit_sel |=> $stable(msel));

  // R8
  busy_implies_ratio_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!hit_rat0 && !hit_rat1) |=> $stable(dval));

endmodule

// File: tb/cpu_clk_ctrl_tb.sv
module cpu_clk_ctrl_tb;

  localparam int MS = 4;
  localparam int DS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cpu_clk_ctrl #(.MUX_SETTLE(MS), .DIV_SETTLE(DS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] sel_enc(input int v);
    return (32'(v & 1) << 16) | (32'((v >> 1) & 1) << 20);
  endfunction

  function automatic logic [31:0] fld(input int f, input int t, input int bitn, input bit moving);
    int a, b;
    a = (f >> bitn) & 1;
    b = (t >> bitn) & 1;
    if (moving && a != b) return 32'd4;
    return b ? 32'd2 : 32'd1;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] junk;
    logic [31:0] cur [2];
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h000, d); chk("R1 sel", d, 32'h0);
    rd(12'h200, d); chk("R1 selst", d, 32'h0011_0000);
    rd(12'h300, d); chk("R1 rat0", d, 32'h0);
    rd(12'h304, d); chk("R1 rat1", d, 32'h0);
    rd(12'h400, d); chk("R1 rat0st", d, 32'h0);
    rd(12'h404, d); chk("R1 rat1st", d, 32'h0);

    // R2 R3 R4 R5: sweep every from/to pair of the two select bits
    junk = 32'h5A5A_5A5A & ~32'h0011_0000;
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        wr(12'h000, sel_enc(f));
        repeat (MS + 1) @(negedge clk);
        wr(12'h000, sel_enc(t) | junk);
        rd(12'h000, d); chk("R2 sel readback", d, sel_enc(t));
        for (int k = 0; k < MS; k++) begin
          rd(12'h200, d);
          chk("R3 core moving", (d >> 16) & 32'h7, fld(f, t, 0, 1'b1));
          chk("R4 perf moving", (d >> 20) & 32'h7, fld(f, t, 1, 1'b1));
          if (f == t) chk("R5 no transition", d, (fld(f, t, 0, 1'b0) << 16) | (fld(f, t, 1, 1'b0) << 20));
          @(negedge clk);
        end
        rd(12'h200, d);
        chk("R3 core final", (d >> 16) & 32'h7, fld(f, t, 0, 1'b0));
        chk("R4 perf final", (d >> 20) & 32'h7, fld(f, t, 1, 1'b0));
      end
    end

    // R6 reversal during a switch: from main, go alternate then back
    wr(12'h000, 32'h0);
    repeat (MS + 1) @(negedge clk);
    wr(12'h000, 32'h0001_0000);
    wr(12'h000, 32'h0);
    repeat (MS - 1) @(negedge clk);
    rd(12'h200, d); chk("R6 held past first end", (d >> 16) & 32'h7, 32'd4);
    repeat (MS - 1) @(negedge clk);
    rd(12'h200, d); chk("R6 still moving", (d >> 16) & 32'h7, 32'd4);
    @(negedge clk);
    rd(12'h200, d); chk("R6 back on main", (d >> 16) & 32'h7, 32'd1);

    // R7 R8 R9: sweep every value pair in both ratio registers
    cur[0] = 32'h0; cur[1] = 32'h0;
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          logic [31:0] val, mask, expst;
          logic [11:0] ra, sa;
          int pb;
          pb = (r == 0) ? 16 : 4;
          ra = (r == 0) ? 12'h300 : 12'h304;
          sa = (r == 0) ? 12'h400 : 12'h404;
          val  = 32'(a) | (32'(b) << pb);
          mask = 32'h7 | (32'h7 << pb);
          expst = 32'(((cur[r] & 32'h7) != 32'(a)) ? 1 : 0)
                | (32'((((cur[r] >> pb) & 32'h7) != 32'(b)) ? 1 : 0) << pb);
          wr(ra, val | (32'hA5A5_A5A5 & ~mask));
          cur[r] = val;
          rd(ra, d); chk("R7 ratio readback", d, val);
          for (int k = 0; k < DS; k++) begin
            rd(sa, d); chk("R8 busy window (R9 when unchanged)", d, expst);
            @(negedge clk);
          end
          rd(sa, d); chk("R8 busy cleared", d, 32'h0);
        end
      end
    end

    // R9 restart of the delay
    wr(12'h300, 32'h0000_0005);
    wr(12'h300, 32'h0000_0002);
    repeat (DS - 1) @(negedge clk);
    rd(12'h400, d); chk("R9 restarted busy", d, 32'h1);
    @(negedge clk);
    rd(12'h400, d); chk("R9 restart ends", d, 32'h0);
    rd(12'h300, d); chk("R9 latest ratio", d, 32'h2);

    // R10 unmapped and status writes
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h302, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h404, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R10 unmapped read", d, 32'h0);
    rd(12'h302, d); chk("R10 misaligned read", d, 32'h0);
    rd(12'h000, d); chk("R10 sel kept", d, 32'h0);
    rd(12'h200, d); chk("R10 selst kept", d, 32'h0011_0000);
    rd(12'h300, d); chk("R10 rat0 kept", d, 32'h2);
    rd(12'h304, d); chk("R10 rat1 kept", d, cur[1]);
    rd(12'h400, d); chk("R10 rat0st idle", d, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule